// File: doc/BRIEF.md
# Finite-Field Inverter over GF(2^233)

This block returns the multiplicative inverse of an element of the binary field GF(2^233), where the field is defined by the trinomial x^233 + x^74 + 1 and elements are held as 233-bit polynomial-basis vectors. It raises the operand to the power 2^233 − 2 by walking an addition chain for the exponent 232. The chain uses 232 squarings and 10 field multiplications in total.

The datapath has one combinational field multiplier, and a combinational squarer follows it. In one clock cycle the pair can give two chained squares (the multiplier squares its operand and the squarer squares the result), a single square (the squarer is bypassed), or a product followed by one square. Folding each product's next square into the same cycle brings one inversion down to 123 working cycles. A caller presents the operand with a one-cycle start pulse and receives the inverse with a one-cycle done pulse. A zero operand gives zero.

Top module: `itt_inverter`

## Requirements
- R1: After reset, done is 0 and inverse is all zeros.
- R2: For a nonzero operand, the field product of inverse and operand, reduced modulo x^233 + x^74 + 1, equals 1 once done pulses.
- R3: An operand of 1 (bit 0 only) gives an inverse of exactly 1.
- R4: An operand of 0 gives an inverse of all zeros.
- R5: An operand of x (bit 1 only) gives an inverse with exactly bits 232 and 73 set.
- R6: The block accepts start at a rising edge while idle. done is high for exactly one cycle, and that cycle begins 123 rising edges after the accepting edge.
- R7: A start seen while a computation runs is ignored. The running result, its timing and the single done pulse are unchanged.
- R8: inverse changes only at the edge that raises done, and it holds its value between completions.
- R9: The operand is sampled only at the accepting edge. Later changes to the operand port have no effect on the running computation.
- R10: A start given in the cycle where done is high is accepted, and it begins a new full computation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to invert the operand, taken only while idle |
| operand | input | 233 | Field element to invert, bit i is the coefficient of x^i |
| inverse | output | 233 | Last computed inverse, held until the next completion |
| done | output | 1 | One-cycle pulse marking a fresh inverse |

## Verification
A wrong intermediate value in the chain registers spreads into every later step. Nothing is visible at the ports until done, at most 123 cycles after start. At that point the inverse times the operand is no longer 1, and the fixed values for 1, 0 and x no longer match. A fault in the sequencer, such as a wrong square count, a wrong link kind or a bad end test, also shows at done: the pulse moves away from edge 123 or never comes, so the bench checks the latency on every run. Ignored starts and operand changes are placed in the middle of a run, so that any leak into the state corrupts that run's result.

// File: rtl/itt_pkg.sv
package itt_pkg;

   // Work done by the datapath in one cycle
   typedef enum logic [1:0] {
      OP_IDLE = 2'd0,   // nothing updated
      OP_SQ2  = 2'd1,   // two chained squares
      OP_SQ1  = 2'd2,   // one square, squarer bypassed
      OP_MUL  = 2'd3    // product, then one square of it
   } itt_op_e;

   // Kind of addition-chain link in progress
   typedef enum logic {
      LNK_DBL = 1'b0,   // exponent index doubles
      LNK_ADD = 1'b1    // exponent index grows by one
   } itt_link_e;

endpackage

// File: rtl/gf_reduce.sv
module gf_reduce #(
   parameter int M = 233,
   parameter int K = 74
) (
   input  logic [2*M-2:0] wide_in,
   output logic [M-1:0]   red_out
);

   logic [2*M-2:0] work;

   // Fold every term of degree >= M back using x^M = x^K + 1, highest first
   always_comb begin
      work = wide_in;
      for (int i = 2*M-2; i >= M; i--) begin
         if (work[i]) begin
            work[i]       = 1'b0;
            work[i-M]     = work[i-M] ^ 1'b1;
            work[i-M+K]   = work[i-M+K] ^ 1'b1;
         end
      end
      red_out = work[M-1:0];
   end

endmodule

// File: rtl/gf_sqr.sv
module gf_sqr #(
   parameter int M = 233,
   parameter int K = 74
) (
   input  logic [M-1:0] x,
   output logic [M-1:0] y
);

   logic [2*M-2:0] spread;

   // Squaring in characteristic two interleaves zeros between the bits
   always_comb begin
      spread = '0;
      for (int i = 0; i < M; i++) begin
         spread[2*i] = x[i];
      end
   end

   gf_reduce #(.M(M), .K(K)) u_red (
      .wide_in (spread),
      .red_out (y)
   );

endmodule

// File: rtl/gf_mul.sv
module gf_mul #(
   parameter int M     = 233,
   parameter int K     = 74,
   parameter int STYLE = 0     // 0: full product then fold, 1: fold per bit
) (
   input  logic [M-1:0] a,
   input  logic [M-1:0] b,
   output logic [M-1:0] p
);

   generate
      if (STYLE == 0) begin : g_school
         logic [2*M-2:0] full;

         always_comb begin
            full = '0;
            for (int i = 0; i < M; i++) begin
               if (b[i]) full = full ^ ({{(M-1){1'b0}}, a} << i);
            end
         end

         gf_reduce #(.M(M), .K(K)) u_red (
            .wide_in (full),
            .red_out (p)
         );
      end else begin : g_interleave
         localparam logic [M-1:0] TAPS = (M'(1) << K) | M'(1);
         logic [M-1:0] acc;
         logic         hi;

         // Horner scheme from the top bit of b, folding at every step
         always_comb begin
            acc = '0;
            hi  = 1'b0;
            for (int i = M-1; i >= 0; i--) begin
               hi  = acc[M-1];
               acc = acc << 1;
               if (hi)   acc = acc ^ TAPS;
               if (b[i]) acc = acc ^ a;
            end
            p = acc;
         end
      end
   endgenerate

endmodule

// File: rtl/itt_seq.sv
module itt_seq
   import itt_pkg::*;
#(
   parameter int M = 233
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    start,
   output logic    busy,
   output itt_op_e op,
   output logic    use_opnd,
   output logic    load,
   output logic    fin
);

   localparam int W = $clog2(M);
   localparam logic [W-1:0] EXP = W'(M-1);

   function automatic int top_bit(input int v);
      int r;
      r = 0;
      for (int i = 0; i < 31; i++) begin
         if (((v >> i) & 1) == 1) r = i;
      end
      return r;
   endfunction

   localparam int P  = top_bit(M-1);
   localparam int BW = (W > 1) ? $clog2(W) : 1;

   logic            busy_q;
   itt_link_e       kind_q;
   logic [BW-1:0]   bitpos_q;
   logic [W-1:0]    cur_q;
   logic [W-1:0]    dcnt_q;
   logic            pend_q;

   itt_op_e         op_c;
   logic            last_link;
   logic            take_add;
   logic [W-1:0]    cur_n;
   logic [W-1:0]    rem_n;

   always_comb begin
      if (!busy_q)             op_c = OP_IDLE;
      else if (dcnt_q != '0)   op_c = OP_SQ2;
      else if (pend_q)         op_c = OP_SQ1;
      else                     op_c = OP_MUL;
   end

   // The chain follows the bits of M-1 below its top bit:
   // each bit doubles the index, and a set bit adds one more link
   assign last_link = (bitpos_q == '0) && ((kind_q == LNK_ADD) || !EXP[0]);
   assign take_add  = (kind_q == LNK_DBL) && EXP[bitpos_q];
   assign cur_n     = (kind_q == LNK_DBL) ? (cur_q << 1) : (cur_q + W'(1));
   // the product cycle already gave one square, so a doubling of j needs j-1 more
   assign rem_n     = cur_n - W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         kind_q   <= LNK_DBL;
         bitpos_q <= '0;
         cur_q    <= '0;
         dcnt_q   <= '0;
         pend_q   <= 1'b0;
      end else if (!busy_q) begin
         if (start) begin
            busy_q   <= 1'b1;
            kind_q   <= LNK_DBL;
            bitpos_q <= BW'(P-1);
            cur_q    <= W'(1);
            dcnt_q   <= '0;
            pend_q   <= 1'b1;     // first link squares the raw operand once
         end
      end else begin
         case (op_c)
            OP_SQ2:  dcnt_q <= dcnt_q - W'(1);
            OP_SQ1:  pend_q <= 1'b0;
            OP_MUL: begin
               if (last_link) begin
                  busy_q <= 1'b0;
               end else begin
                  cur_q <= cur_n;
                  if (take_add) begin
                     kind_q <= LNK_ADD;
                     dcnt_q <= '0;
                     pend_q <= 1'b0;
                  end else begin
                     kind_q   <= LNK_DBL;
                     bitpos_q <= bitpos_q - BW'(1);
                     dcnt_q   <= rem_n >> 1;
                     pend_q   <= rem_n[0];
                  end
               end
            end
            default: ;
         endcase
      end
   end

   assign busy     = busy_q;
   assign op       = op_c;
   assign use_opnd = (kind_q == LNK_ADD);
   assign load     = start && !busy_q;
   assign fin      = busy_q && (op_c == OP_MUL) && last_link;

endmodule

// File: rtl/itt_inverter.sv
module itt_inverter
   import itt_pkg::*;
#(
   parameter int M         = 233,
   parameter int K         = 74,
   parameter int MUL_STYLE = 0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [M-1:0] operand,
   output logic [M-1:0] inverse,
   output logic         done
);

   generate
      if (M < 3) begin : g_bad_m
         $error("itt_inverter: field degree must be at least 3");
      end
      if (K < 1 || K >= M) begin : g_bad_k
         $error("itt_inverter: middle tap must lie strictly between 0 and M");
      end
      if (MUL_STYLE != 0 && MUL_STYLE != 1) begin : g_bad_style
         $error("itt_inverter: MUL_STYLE must be 0 or 1");
      end
   endgenerate

   logic         busy;
   itt_op_e      op;
   logic         use_opnd;
   logic         load;
   logic         fin;

   logic [M-1:0] opnd_q;    // sampled operand, beta_1
   logic [M-1:0] bprev_q;   // last chain product
   logic [M-1:0] t_q;       // running value being squared
   logic [M-1:0] mul_b;
   logic [M-1:0] prod;
   logic [M-1:0] sq_out;

   itt_seq #(.M(M)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .busy     (busy),
      .op       (op),
      .use_opnd (use_opnd),
      .load     (load),
      .fin      (fin)
   );

   // Squaring cycles feed t to both multiplier inputs
   assign mul_b = (op == OP_MUL) ? (use_opnd ? opnd_q : bprev_q) : t_q;

   gf_mul #(.M(M), .K(K), .STYLE(MUL_STYLE)) u_mul (
      .a (t_q),
      .b (mul_b),
      .p (prod)
   );

   gf_sqr #(.M(M), .K(K)) u_sqr (
      .x (prod),
      .y (sq_out)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         opnd_q  <= '0;
         bprev_q <= '0;
         t_q     <= '0;
         inverse <= '0;
         done    <= 1'b0;
      end else begin
         done <= 1'b0;
         if (load) begin
            opnd_q  <= operand;
            bprev_q <= operand;
            t_q     <= operand;
         end
         case (op)
            OP_SQ2: t_q <= sq_out;
            OP_SQ1: t_q <= prod;
            OP_MUL: begin
               t_q     <= sq_out;
               bprev_q <= prod;
               if (fin) begin
                  inverse <= sq_out;   // square of beta_(M-1)
                  done    <= 1'b1;
               end
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/itt_inverter_chk.sv
module itt_inverter_chk #(
   parameter int M = 233
) (
   input logic         clk,
   input logic         rst_n,
   input logic         start,
   input logic [M-1:0] operand,
   input logic [M-1:0] inverse,
   input logic         done,
   input logic         busy
);

   logic [M-1:0] cap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cap <= '0;
      else if (start && !busy) cap <= operand;
   end

   assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_after_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(busy));

   assert_inverse_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(inverse));

   assert_zero_in_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (done && cap == '0) |-> (inverse == '0));

   assert_unit_in_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (done && cap == M'(1)) |-> (inverse == M'(1)));

endmodule

bind itt_inverter itt_inverter_chk #(.M(M)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start   (start),
   .operand (operand),
   .inverse (inverse),
   .done    (done),
   .busy    (busy)
);

// File: tb/tb_itt_inverter.sv
module tb_itt_inverter;

   localparam int M   = 233;
   localparam int K   = 74;
   localparam int LAT = 123;
   localparam int NV  = 6;
   localparam logic [M-1:0] TAPS = (M'(1) << K) | M'(1);

   localparam logic [M-1:0] VEC [NV] = '{
      233'h1_8c3a_5f27_9e41_d0b6_2a7c_e593_0f1d_6b84_c2e7_19a5_f360_d84b_7e29,
      233'h3,
      {M{1'b1}},
      233'h1_0000_0000_0000_0000_0000_0000_0000_0000_0000_0000_0000_0000_0000,
      233'h0_5a5a_c3c3_0ff0_9669_1234_5678_9abc_def0_2468_ace1_3579_bdf0_8421,
      233'h7_2f91_4c0e_a3b8_6d15
   };

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [M-1:0] operand = '0;
   logic [M-1:0] inverse;
   logic         done;

   int errors = 0;
   int checks = 0;

   itt_inverter dut (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .operand (operand),
      .inverse (inverse),
      .done    (done)
   );

   always #10 clk = ~clk;

   // Reference field product, bit-serial from the low end of b
   function automatic logic [M-1:0] fmul(input logic [M-1:0] a, input logic [M-1:0] b);
      logic [M-1:0] aa;
      logic [M-1:0] acc;
      logic         hi;
      aa  = a;
      acc = '0;
      for (int i = 0; i < M; i++) begin
         if (b[i]) acc = acc ^ aa;
         hi = aa[M-1];
         aa = aa << 1;
         if (hi) aa = aa ^ TAPS;
      end
      return acc;
   endfunction

   task automatic chk(input logic ok, input string tag, input logic [M-1:0] act, input logic [M-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Called at a falling edge; start is taken at the next rising edge
   task automatic launch(input logic [M-1:0] op);
      operand = op;
      start   = 1'b1;
      @(negedge clk);
      start   = 1'b0;
   endtask

   // mode 1: extra start with a new operand mid-run; operand kept changed
   task automatic wait_done(input int mode, output int cyc);
      cyc = 0;
      while (!done && cyc < LAT + 60) begin
         @(negedge clk);
         cyc++;
         if (mode == 1 && cyc == 40) begin
            operand = M'(1);
            start   = 1'b1;
         end
         if (mode == 1 && cyc == 41) start = 1'b0;
      end
   endtask

   initial begin
      #(20 * 150000);
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int cyc;
      int extra;
      logic [M-1:0] held;
      logic [M-1:0] xin;
      logic [M-1:0] xinv;

      repeat (3) @(negedge clk);
      // R1: reset state
      chk(done == 1'b0, "R1 done in reset", M'(done), '0);
      chk(inverse == '0, "R1 inverse in reset", inverse, '0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(done == 1'b0 && inverse == '0, "R1 after release", inverse, '0);

      // R2, R6: vector table
      for (int v = 0; v < NV; v++) begin
         launch(VEC[v]);
         wait_done(0, cyc);
         chk(cyc == LAT, "R6 latency", M'(cyc), M'(LAT));
         chk(fmul(inverse, VEC[v]) == M'(1), "R2 product with operand", fmul(inverse, VEC[v]), M'(1));
         @(negedge clk);
         chk(done == 1'b0, "R6 single-cycle done", M'(done), '0);
      end

      // R3: unit element
      launch(M'(1));
      wait_done(0, cyc);
      chk(inverse == M'(1), "R3 inverse of one", inverse, M'(1));
      @(negedge clk);

      // R4: zero
      launch('0);
      wait_done(0, cyc);
      chk(cyc == LAT, "R4 latency of zero run", M'(cyc), M'(LAT));
      chk(inverse == '0, "R4 inverse of zero", inverse, '0);
      @(negedge clk);

      // R5: x
      xin  = M'(2);
      xinv = (M'(1) << 232) | (M'(1) << 73);
      launch(xin);
      wait_done(0, cyc);
      chk(inverse == xinv, "R5 inverse of x", inverse, xinv);

      // R8: hold between completions
      held = inverse;
      extra = 0;
      for (int c = 0; c < 20; c++) begin
         @(negedge clk);
         if (done) extra++;
         if (inverse != held) extra++;
      end
      chk(extra == 0, "R8 inverse held while idle", inverse, held);

      // R7, R9: mid-run start and operand change
      launch(VEC[0]);
      wait_done(1, cyc);
      chk(cyc == LAT, "R7 latency with ignored start", M'(cyc), M'(LAT));
      chk(fmul(inverse, VEC[0]) == M'(1), "R9 result uses sampled operand",
          fmul(inverse, VEC[0]), M'(1));
      held = inverse;
      extra = 0;
      for (int c = 0; c < LAT + 20; c++) begin
         @(negedge clk);
         if (done) extra++;
      end
      chk(extra == 0, "R7 no second done from ignored start", M'(extra), '0);
      chk(inverse == held, "R7 inverse unchanged after run", inverse, held);

      // R10: start in the done cycle
      launch(VEC[4]);
      wait_done(0, cyc);
      launch(VEC[2]);
      chk(done == 1'b0, "R10 done drops after restart", M'(done), '0);
      wait_done(0, cyc);
      chk(cyc == LAT - 1 + 1, "R10 back-to-back latency", M'(cyc), M'(LAT));
      chk(fmul(inverse, VEC[2]) == M'(1), "R10 back-to-back result",
          fmul(inverse, VEC[2]), M'(1));

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule